// File: doc/BRIEF.md
# Keyed Numerically Controlled Oscillator

This block is a digital tone generator for a reference clock domain. A 28-bit phase register advances on every clock by a tuning word, so the tone frequency is f_clk × word / 2^28. A phase offset is added to the top of the running phase before the phase is turned into amplitude. The block drives three outputs from that phase: a signed sine sample from an internal table, a one-bit square wave and an unsigned triangle ramp.

Two tuning words and four phase offsets are held in a small register bank, loaded through a synchronous write port. A one-bit frequency select picks the active tuning word and a two-bit phase select picks the active offset. Toggling these selects at run time produces binary frequency keying and two- or four-level phase keying without disturbing the running phase. A synchronous reset returns the phase to zero, so several copies on one clock start from a common origin. One copy can then be given a quarter-turn offset to form an in-phase/quadrature pair.

Top module: `nco_keyed`

## Requirements
- R1: On every clock edge with reset released, the phase register advances by the active tuning word, modulo 2^28.
- R2: `fsel`=0 selects tuning word 0 and `fsel`=1 selects tuning word 1. A change of `fsel` or of a tuning word never reloads or clears the phase register, so the phase stays continuous.
- R3: `psel` picks one of four 12-bit phase offsets. The chosen offset is added at phase bits [27:16], which shifts the output phase by offset×360/4096 degrees without changing the frequency. An offset of 1024 is +90°, 2048 is 180° and 3072 is -90°.
- R4: `sine_out` equals round(511 × sin(2π·a/1024)) within one LSB, where a is bits [27:18] of the offset phase. The lower phase bits are truncated.
- R5: `square_out` is bit 27 of the offset phase.
- R6: `tri_out` is bits [26:17] of the offset phase. When bit 27 is set, those bits are inverted.
- R7: A write (`wr_en`=1) to `wr_addr` 0 or 1 loads tuning word 0 or 1 from `wr_data`. A write to 4..7 loads phase offset 0..3 from `wr_data`[11:0]. Addresses 2 and 3 change nothing. A written value first affects the phase on the clock edge after the write edge.
- R8: While `rst_n` is low at a clock edge, the phase register, all tuning words, all offsets and all outputs clear to zero. Two instances released on the same edge stay in a fixed phase relationship, set only by their offsets.
- R9: The outputs registered at edge t reflect the phase held just before edge t, combined with the offset that `psel` selects at edge t. This gives one cycle of latency from the phase register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Register address (0,1 tuning words; 4..7 offsets) |
| wr_data | input | 28 | Write data |
| fsel | input | 1 | Tuning word select |
| psel | input | 2 | Phase offset select |
| sine_out | output | 10 | Signed sine sample |
| square_out | output | 1 | Square wave |
| tri_out | output | 10 | Unsigned triangle sample |

## Verification
The hardest cases are the ones where keying and configuration collide on one edge. Examples are a select toggling on the same edge that rewrites the register it selects, or a tuning word that makes the phase wrap past 2^28 while an offset pushes it across the sign boundary. These are hard to reach from a plain tone test, so a seeded random phase issues writes to every address, including the dead ones, while both selects change at random. A model in the bench tracks the phase exactly. A mid-run reset then checks realignment of two instances that differ only in their phase select.

// File: rtl/nco_pkg.sv
// Shared definitions for the keyed oscillator.
// Assumes elaboration-time real arithmetic is available for table generation.
package nco_pkg;

    // Register bank addresses; the low two bits of an offset address pick the slot.
    typedef enum logic [2:0] {
        ADR_FREQ0 = 3'd0,
        ADR_FREQ1 = 3'd1,
        ADR_OFS0  = 3'd4,
        ADR_OFS1  = 3'd5,
        ADR_OFS2  = 3'd6,
        ADR_OFS3  = 3'd7
    } nco_addr_e;

    // Rounded sine code for table entry idx of a 2^aw table, amplitude 2^(ampw-1)-1.
    function automatic int sine_code(input int idx, input int aw, input int ampw);
        real pi_c;
        real x;
        real term;
        real s;
        pi_c = 3.14159265358979323846;
        x = 2.0 * pi_c * real'(idx) / (2.0 ** aw);
        if (x > pi_c) x = x - 2.0 * pi_c;
        s = x;
        term = x;
        for (int n = 1; n < 12; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            s = s + term;
        end
        s = s * ((2.0 ** (ampw - 1)) - 1.0);
        if (s >= 0.0) return $rtoi(s + 0.5);
        return -$rtoi(-s + 0.5);
    endfunction

endpackage

// File: rtl/nco_regfile.sv
// Tuning word and phase offset bank with run-time selection.
// Holds NFREQ tuning words and NOFS offsets; writes land on the write edge,
// so the selected value is first used on the following edge.
module nco_regfile #(
    parameter int ACC_W  = 28,
    parameter int PH_W   = 12,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    input  logic              fsel,
    input  logic [1:0]        psel,
    output logic [ACC_W-1:0]  freq_active,
    output logic [PH_W-1:0]   ofs_active
);
    import nco_pkg::*;

    localparam int NFREQ = 2;
    localparam int NOFS  = 4;
    localparam logic [ADDR_W-1:0] OFS_BASE = ADDR_W'(ADR_OFS0);

    logic [ACC_W-1:0] freq_q [NFREQ];
    logic [PH_W-1:0]  ofs_q  [NOFS];

    genvar g;
    generate
        for (g = 0; g < NFREQ; g++) begin : g_freq
            // Load one tuning word when its address is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    freq_q[g] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g))
                    freq_q[g] <= wr_data;
            end
        end
        for (g = 0; g < NOFS; g++) begin : g_ofs
            // Load one phase offset from the low data bits when its address is written.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ofs_q[g] <= '0;
                else if (wr_en && wr_addr == OFS_BASE + ADDR_W'(g))
                    ofs_q[g] <= wr_data[PH_W-1:0];
            end
        end
    endgenerate

    // Present the selected tuning word and offset.
    always_comb begin
        freq_active = freq_q[fsel];
        ofs_active  = ofs_q[psel];
    end

    // R7: a write to tuning word 0 is what the accumulator sees next, if still selected.
    p_freq_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(ADR_FREQ0) && !fsel)
            |=> (fsel || freq_active == $past(wr_data)));

    // R3: a write to the selected offset slot appears at the offset output next cycle.
    p_ofs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == (OFS_BASE + ADDR_W'(psel)))
            |=> (psel != $past(psel) || ofs_active == $past(wr_data[PH_W-1:0])));

endmodule

// File: rtl/nco_phase_acc.sv
// Free-running phase accumulator, modulo 2^ACC_W.
// Assumes the step input is already the selected tuning word; never reloaded by keying.
module nco_phase_acc #(
    parameter int ACC_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase
);

    // Advance the phase by the step each clock, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else
            phase <= phase + step;
    end

    // R8: reset leaves the phase at the common origin.
    p_reset_origin_r8: assert property (@(posedge clk)
        !rst_n |=> (phase == '0));

endmodule

// File: rtl/nco_shaper.sv
// Phase-to-amplitude stage: adds the phase offset to the top phase bits and
// registers a sine sample, a square bit and a triangle ramp (one cycle latency).
// Sine table contents are computed at elaboration from nco_pkg::sine_code.
module nco_shaper #(
    parameter int ACC_W  = 28,
    parameter int PH_W   = 12,
    parameter int LUT_AW = 10,
    parameter int AMP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ACC_W-1:0]        phase,
    input  logic [PH_W-1:0]         ofs,
    output logic signed [AMP_W-1:0] sine_out,
    output logic                    square_out,
    output logic [AMP_W-1:0]        tri_out
);
    import nco_pkg::*;

    localparam int LUT_DEPTH = 1 << LUT_AW;
    localparam int LOW_W     = ACC_W - PH_W;

    logic [PH_W-1:0]         ph_top;
    logic [LUT_AW-1:0]       lut_addr;
    logic [AMP_W-1:0]        ramp;
    logic signed [AMP_W-1:0] lut_mem [LUT_DEPTH];
    logic                    unused_bits;

    genvar k;
    generate
        for (k = 0; k < LUT_DEPTH; k++) begin : g_lut
            localparam int CODE = sine_code(k, LUT_AW, AMP_W);
            assign lut_mem[k] = CODE[AMP_W-1:0];
        end
    endgenerate

    // Offset lands on the top PH_W bits; lower phase bits cannot carry into them.
    always_comb begin
        ph_top   = phase[ACC_W-1 -: PH_W] + ofs;
        lut_addr = ph_top[PH_W-1 -: LUT_AW];
        ramp     = ph_top[PH_W-2 -: AMP_W];
    end

    assign unused_bits = ^{phase[LOW_W-1:0], ph_top};

    // Register the three waveform samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sine_out   <= '0;
            square_out <= 1'b0;
            tri_out    <= '0;
        end else begin
            sine_out   <= lut_mem[lut_addr];
            square_out <= ph_top[PH_W-1];
            tri_out    <= ph_top[PH_W-1] ? ~ramp : ramp;
        end
    end

    // R5: the square bit marks the half cycle where the sine is not positive.
    p_square_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
        square_out |-> (sine_out <= 0));

    // R4: in the other half cycle the sine is not negative.
    p_sine_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !square_out |-> (sine_out >= 0));

endmodule

// File: rtl/nco_keyed.sv
// Keyed oscillator top: register bank, phase accumulator and waveform stage.
// Assumes one clock domain; select inputs are synchronous to clk.
module nco_keyed #(
    parameter int ACC_W  = 28,
    parameter int PH_W   = 12,
    parameter int LUT_AW = 10,
    parameter int AMP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              wr_addr,
    input  logic [ACC_W-1:0]        wr_data,
    input  logic                    fsel,
    input  logic [1:0]              psel,
    output logic signed [AMP_W-1:0] sine_out,
    output logic                    square_out,
    output logic [AMP_W-1:0]        tri_out
);

    logic [ACC_W-1:0] freq_active;
    logic [PH_W-1:0]  ofs_active;
    logic [ACC_W-1:0] phase;

    nco_regfile #(.ACC_W(ACC_W), .PH_W(PH_W), .ADDR_W(3)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .fsel        (fsel),
        .psel        (psel),
        .freq_active (freq_active),
        .ofs_active  (ofs_active)
    );

    nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (freq_active),
        .phase (phase)
    );

    nco_shaper #(.ACC_W(ACC_W), .PH_W(PH_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_shape (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .ofs        (ofs_active),
        .sine_out   (sine_out),
        .square_out (square_out),
        .tri_out    (tri_out)
    );

    // R1 and R2: the phase moves by exactly the word the bank selected, whatever keying did.
    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase == $past(phase) + $past(freq_active)));

endmodule

// File: tb/test_nco_keyed.sv
// Bench for nco_keyed: a cycle model of the phase drives expected outputs for
// two instances that share all inputs except the phase select.
module test_nco_keyed;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [27:0]       wr_data = '0;
    logic              fsel = 1'b0;
    logic [1:0]        psel = '0;
    logic [1:0]        q_psel = '0;
    logic signed [9:0] sine_i, sine_q;
    logic              sq_i, sq_q;
    logic [9:0]        tri_i, tri_q;

    int    total = 0;
    int    bad = 0;
    bit    chk_on = 1'b0;
    bit    finished = 1'b0;
    string tag = "R8 reset";

    // model state
    logic [27:0] m_acc = '0;
    logic [27:0] m_f [2];
    logic [11:0] m_o [4];
    int          e_sin_i = 0, e_sin_q = 0;
    logic        e_sq_i = 1'b0, e_sq_q = 1'b0;
    logic [9:0]  e_tri_i = '0, e_tri_q = '0;

    always #5 clk = ~clk;

    nco_keyed i_nco_keyed (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fsel(fsel), .psel(psel), .sine_out(sine_i), .square_out(sq_i), .tri_out(tri_i)
    );

    nco_keyed i_nco_keyed_q (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fsel(fsel), .psel(q_psel), .sine_out(sine_q), .square_out(sq_q), .tri_out(tri_q)
    );

    function automatic int ref_sine(input logic [27:0] p);
        real s;
        s = $sin(2.0 * 3.14159265358979323846 * real'(p[27:18]) / 1024.0) * 511.0;
        if (s >= 0.0) return $rtoi(s + 0.5);
        return -$rtoi(-s + 0.5);
    endfunction

    function automatic logic [9:0] ref_tri(input logic [27:0] p);
        return p[27] ? ~p[26:17] : p[26:17];
    endfunction

    // Cycle model of the requirements, evaluated on pre-edge input values.
    always @(posedge clk) begin
        logic [27:0] pi_v, pq_v;
        if (!rst_n) begin
            m_acc = '0;
            foreach (m_f[i]) m_f[i] = '0;
            foreach (m_o[i]) m_o[i] = '0;
            e_sin_i = 0; e_sin_q = 0; e_sq_i = 0; e_sq_q = 0; e_tri_i = '0; e_tri_q = '0;
        end else begin
            pi_v = m_acc + {m_o[psel], 16'b0};
            pq_v = m_acc + {m_o[q_psel], 16'b0};
            e_sin_i = ref_sine(pi_v); e_sq_i = pi_v[27]; e_tri_i = ref_tri(pi_v);
            e_sin_q = ref_sine(pq_v); e_sq_q = pq_v[27]; e_tri_q = ref_tri(pq_v);
            m_acc = m_acc + m_f[fsel];
            if (wr_en) begin
                if (wr_addr == 3'd0) m_f[0] = wr_data;
                else if (wr_addr == 3'd1) m_f[1] = wr_data;
                else if (wr_addr[2]) m_o[wr_addr[1:0]] = wr_data[11:0];
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input int tol);
        int d;
        total++;
        d = act - exp;
        if (d < -tol || d > tol) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare both instances away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !finished) begin
            chk({tag, " R4 sine I"}, int'(sine_i), e_sin_i, 1);
            chk({tag, " R5 square I"}, int'(sq_i), int'(e_sq_i), 0);
            chk({tag, " R6 tri I"}, int'(tri_i), int'(e_tri_i), 0);
            chk({tag, " R4 sine Q"}, int'(sine_q), e_sin_q, 1);
            chk({tag, " R5 square Q"}, int'(sq_q), int'(e_sq_q), 0);
            chk({tag, " R6 tri Q"}, int'(tri_q), int'(e_tri_q), 0);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [27:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R8: reset state and zero-register hold
        repeat (3) @(negedge clk);
        chk_on = 1'b1;
        cycles(2);
        rst_n = 1'b1;
        tag = "R8 idle after reset";
        cycles(6);
        // R7 R9 R1: first tuning word, one cycle latency
        tag = "R7 R9 R1 tone";
        wr(3'd0, 28'h0100000);
        cycles(300);
        // R7: dead addresses change nothing
        tag = "R7 dead address";
        wr(3'd2, 28'hFFFFFFF);
        wr(3'd3, 28'h5A5A5A5);
        cycles(60);
        // R2: frequency keying with continuous phase
        tag = "R2 FSK";
        wr(3'd1, 28'h0300000);
        for (int i = 0; i < 10; i++) begin
            fsel = ~fsel;
            cycles(37);
        end
        fsel = 1'b0;
        // R3: phase keying over quadrant offsets
        tag = "R3 PSK";
        wr(3'd5, 28'd1024);
        wr(3'd6, 28'd3072);
        wr(3'd7, 28'h0000800);
        for (int i = 0; i < 12; i++) begin
            psel = 2'(i);
            q_psel = 2'(i + 1);
            cycles(23);
        end
        // R1: wrap past 2^28
        tag = "R1 wrap";
        wr(3'd0, 28'hFFFFFFB);
        cycles(100);
        // R8: mid-run reset realigns I and Q
        tag = "R8 realign I/Q";
        @(negedge clk); rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        psel = 2'd0; q_psel = 2'd1;
        wr(3'd5, 28'd1024);
        wr(3'd0, 28'h0234567);
        cycles(400);
        // R1 R2 R3: seeded random keying and writes
        tag = "R1 R2 R3 random";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            wr_en = ($urandom % 6) == 0;
            wr_addr = 3'($urandom);
            wr_data = 28'($urandom);
            if (($urandom % 5) == 0) fsel = 1'($urandom);
            if (($urandom % 4) == 0) psel = 2'($urandom);
            if (($urandom % 4) == 0) q_psel = 2'($urandom);
        end
        @(negedge clk);
        wr_en = 1'b0;
        cycles(20);
        finish_run();
    end

endmodule